// File: doc/BRIEF.md
# Condition-Code Adder and Conditional Branch Resolver

This block is the arithmetic and branch-resolution slice of a 16-bit processor datapath. One shared adder carries out addition, subtraction, comparison, increment and decrement on two operands. Each operation produces a result and a 4-bit condition-code nibble (negative, zero, overflow, carry). Subtraction forms destination minus source and reports a borrow in the carry flag. Comparison forms source minus destination and keeps the destination as its result, so nothing new is written back.

Alongside the adder, a branch resolver decodes the high byte of a branch instruction word and tests the current condition codes. It covers the unconditional branch, the equality tests, the signed orderings and the unsigned orderings. It also forms the branch target: the updated PC (the address after the branch word) plus twice the sign-extended 8-bit word offset held in the low byte. Both results are registered, so they are ready one clock after their inputs are presented.

Top module: `ccb_unit`

## Requirements
- R1: The flag nibble is packed as N in bit 3, Z in bit 2, V in bit 1 and C in bit 0, on both `flags_i` and `flags_o`. While `rst_n` is low, every output is zero.
- R2: Operation code 0 (add) gives dst+src modulo 2^16. C is the carry out. V is set when both operands have the same sign and the result's sign differs from it. N is result bit 15. Z is set when the result is zero.
- R3: Operation code 1 (subtract) gives dst−src. C is set when a borrow occurs (src > dst, unsigned). V is set when the operand signs differ and the result's sign equals the sign of src. N and Z follow the result.
- R4: Operation code 2 (compare) sets N, Z, V and C as for src−dst: C is set when dst > src (unsigned), and V is set on signed overflow of that difference. `result_o` equals dst unchanged.
- R5: Operation code 3 (increment) gives dst+1, and code 4 (decrement) gives dst−1. Both leave C equal to the incoming C. V is set only when incrementing 0x7FFF or decrementing 0x8000.
- R6: Operation codes 5 to 7 pass dst to `result_o` and copy `flags_i` to `flags_o` unchanged.
- R7: A branch word with high byte 0x01 is always taken. For every branch word, the target is `pc_i` + 2×(sign-extended low byte), modulo 2^PC_W.
- R8: An offset byte of 0xFF gives a target of `pc_i`−2, which is the address of the branch word itself.
- R9: Signed conditions use these high bytes: 0x05 is taken when N⊕V, 0x04 when not N⊕V, 0x06 when neither Z nor N⊕V, and 0x07 when Z or N⊕V.
- R10: Unsigned conditions use these high bytes: 0x82 is taken when neither C nor Z, 0x83 when C or Z, 0x86 when C is clear, and 0x87 when C is set.
- R11: High byte 0x03 is taken when Z is set, and 0x02 when Z is clear. Every other high byte is never taken.
- R12: `result_o`, `flags_o`, `taken_o` and `target_o` reflect the inputs sampled at the previous rising clock edge, and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | DATA_W | Source operand |
| dst_i | input | DATA_W | Destination operand |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 inc, 4 dec) |
| flags_i | input | 4 | Current condition codes {N,Z,V,C} |
| br_instr_i | input | 16 | Branch instruction word: condition byte and offset byte |
| pc_i | input | PC_W | Updated PC, the address following the branch word |
| result_o | output | DATA_W | Operation result |
| flags_o | output | 4 | New condition codes {N,Z,V,C} |
| taken_o | output | 1 | Branch condition satisfied |
| target_o | output | PC_W | Branch target address |

## Verification
Every result of the block is due exactly one rising edge after its operands. The result, the flag nibble, the taken bit and the target all come from a single register stage. The bench changes inputs on falling edges and checks on the next falling edge, which lies half a period after the capturing edge. One directed test also reads the outputs just after a new stimulus, before any edge, to confirm that the previous values still hold. The reset check holds `rst_n` low with non-zero inputs across several edges.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

   // operation codes
   localparam logic [2:0] OP_ADD = 3'd0;
   localparam logic [2:0] OP_SUB = 3'd1;
   localparam logic [2:0] OP_CMP = 3'd2;
   localparam logic [2:0] OP_INC = 3'd3;
   localparam logic [2:0] OP_DEC = 3'd4;

   // condition byte codes (high byte of a branch word)
   localparam logic [7:0] BC_ALWAYS = 8'h01;
   localparam logic [7:0] BC_NE     = 8'h02;
   localparam logic [7:0] BC_EQ     = 8'h03;
   localparam logic [7:0] BC_GE     = 8'h04;
   localparam logic [7:0] BC_LT     = 8'h05;
   localparam logic [7:0] BC_GT     = 8'h06;
   localparam logic [7:0] BC_LE     = 8'h07;
   localparam logic [7:0] BC_HI     = 8'h82;
   localparam logic [7:0] BC_LOS    = 8'h83;
   localparam logic [7:0] BC_HIS    = 8'h86;
   localparam logic [7:0] BC_LO     = 8'h87;

   localparam int BR_WORD_W = 16;
   localparam int BR_OFS_W  = 8;

   // condition code nibble: n is bit 3, c is bit 0
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

endpackage

// File: rtl/ccb_alu.sv
module ccb_alu
   import ccb_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic [2:0]        op,
   input  ccr_t              flg_in,
   output logic [DATA_W-1:0] res,
   output ccr_t              flg_out
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] add_a, add_b;
   logic              add_cin;
   logic [DATA_W:0]   sum;
   logic              ovf;
   logic              known_op;

   // operand steering onto one shared adder
   always_comb begin
      add_a    = dst;
      add_b    = '0;
      add_cin  = 1'b0;
      known_op = 1'b1;
      unique case (op)
         OP_ADD: begin add_a = dst; add_b = src;  add_cin = 1'b0; end
         OP_SUB: begin add_a = dst; add_b = ~src; add_cin = 1'b1; end
         OP_CMP: begin add_a = src; add_b = ~dst; add_cin = 1'b1; end
         OP_INC: begin add_a = dst; add_b = '0;   add_cin = 1'b1; end
         OP_DEC: begin add_a = dst; add_b = '1;   add_cin = 1'b0; end
         default: known_op = 1'b0;
      endcase
   end

   assign sum = {1'b0, add_a} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_cin};
   assign ovf = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);

   always_comb begin
      res     = dst;
      flg_out = flg_in;
      if (known_op) begin
         if (op != OP_CMP) res = sum[MSB:0];
         flg_out.n = sum[MSB];
         flg_out.z = (sum[MSB:0] == '0);
         flg_out.v = ovf;
         case (op)
            OP_ADD:         flg_out.c = sum[DATA_W];
            OP_SUB, OP_CMP: flg_out.c = ~sum[DATA_W];
            default:        flg_out.c = flg_in.c;
         endcase
      end
   end

endmodule

// File: rtl/ccb_branch.sv
module ccb_branch
   import ccb_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic [BR_WORD_W-1:0] instr,
   input  logic [PC_W-1:0]      pc,
   input  ccr_t                 flg,
   output logic                 taken,
   output logic [PC_W-1:0]      target
);

   localparam int EXT_W = PC_W - BR_OFS_W - 1;

   logic [7:0]            cond;
   logic [BR_OFS_W-1:0]   ofs;
   logic [PC_W-1:0]       byte_disp;
   logic                  lt;

   assign cond = instr[BR_WORD_W-1:BR_OFS_W];
   assign ofs  = instr[BR_OFS_W-1:0];
   assign lt   = flg.n ^ flg.v;

   // word offset -> byte displacement
   assign byte_disp = {{EXT_W{ofs[BR_OFS_W-1]}}, ofs, 1'b0};
   assign target    = pc + byte_disp;

   always_comb begin
      case (cond)
         BC_ALWAYS: taken = 1'b1;
         BC_NE:     taken = ~flg.z;
         BC_EQ:     taken = flg.z;
         BC_GE:     taken = ~lt;
         BC_LT:     taken = lt;
         BC_GT:     taken = ~(flg.z | lt);
         BC_LE:     taken = flg.z | lt;
         BC_HI:     taken = ~(flg.c | flg.z);
         BC_LOS:    taken = flg.c | flg.z;
         BC_HIS:    taken = ~flg.c;
         BC_LO:     taken = flg.c;
         default:   taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/ccb_unit.sv
module ccb_unit
   import ccb_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int PC_W    = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    src_i,
   input  logic [DATA_W-1:0]    dst_i,
   input  logic [2:0]           op_i,
   input  logic [3:0]           flags_i,
   input  logic [BR_WORD_W-1:0] br_instr_i,
   input  logic [PC_W-1:0]      pc_i,
   output logic [DATA_W-1:0]    result_o,
   output logic [3:0]           flags_o,
   output logic                 taken_o,
   output logic [PC_W-1:0]      target_o
);

   localparam int MIN_PC_W = BR_OFS_W + 2;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("ccb_unit: DATA_W must be at least 2");
   end
   if (PC_W < MIN_PC_W) begin : g_bad_pc_w
      $error("ccb_unit: PC_W too narrow for the branch displacement");
   end

   logic [DATA_W-1:0] alu_res;
   ccr_t              alu_flg;
   logic              br_taken;
   logic [PC_W-1:0]   br_tgt;

   ccb_alu #(.DATA_W(DATA_W)) alu_i (
      .src     (src_i),
      .dst     (dst_i),
      .op      (op_i),
      .flg_in  (ccr_t'(flags_i)),
      .res     (alu_res),
      .flg_out (alu_flg)
   );

   ccb_branch #(.PC_W(PC_W)) br_i (
      .instr  (br_instr_i),
      .pc     (pc_i),
      .flg    (ccr_t'(flags_i)),
      .taken  (br_taken),
      .target (br_tgt)
   );

   if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] res_q;
      ccr_t              flg_q;
      logic              taken_q;
      logic [PC_W-1:0]   tgt_q;
      logic              past_ok;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q   <= '0;
            flg_q   <= '0;
            taken_q <= 1'b0;
            tgt_q   <= '0;
            past_ok <= 1'b0;
         end else begin
            res_q   <= alu_res;
            flg_q   <= alu_flg;
            taken_q <= br_taken;
            tgt_q   <= br_tgt;
            past_ok <= 1'b1;
         end
      end

      assign result_o = res_q;
      assign flags_o  = flg_q;
      assign taken_o  = taken_q;
      assign target_o = tgt_q;

      AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
         |-> (flags_o[0] == $past(flags_i[0]))); // R5

      AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(op_i) == OP_CMP) |-> (result_o == $past(dst_i))); // R4

      AST_UNDEF_OP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(op_i) > OP_DEC)
         |-> (flags_o == $past(flags_i) && result_o == $past(dst_i))); // R6

      AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(br_instr_i[15:8]) == BC_ALWAYS) |-> taken_o); // R7

      AST_SELF_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(br_instr_i[7:0]) == 8'hFF)
         |-> (target_o == $past(pc_i) - PC_W'(2))); // R8

      AST_LO_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(br_instr_i[15:8]) == BC_LO)
         |-> (taken_o == $past(flags_i[0]))); // R10
   end else begin : g_comb
      assign result_o = alu_res;
      assign flags_o  = alu_flg;
      assign taken_o  = br_taken;
      assign target_o = br_tgt;
   end

endmodule

// File: tb/ccb_unit_tb_top.sv
module ccb_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_i = '0;
   logic [15:0] dst_i = '0;
   logic [2:0]  op_i = 3'd5;
   logic [3:0]  flags_i = '0;
   logic [15:0] br_instr_i = '0;
   logic [15:0] pc_i = '0;
   logic [15:0] result_o;
   logic [3:0]  flags_o;
   logic        taken_o;
   logic [15:0] target_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ccb_unit dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .dst_i(dst_i), .op_i(op_i),
      .flags_i(flags_i), .br_instr_i(br_instr_i), .pc_i(pc_i),
      .result_o(result_o), .flags_o(flags_o), .taken_o(taken_o), .target_o(target_o)
   );

   // {op, src, dst, flags_in, expected result, expected flags}
   localparam int NV = 19;
   localparam logic [58:0] VEC [NV] = '{
      {3'd0, 16'd1,     16'd1,     4'h0, 16'd2,     4'h0}, // R2 plain
      {3'd0, 16'd1,     16'd32767, 4'h0, 16'd32768, 4'hA}, // R2 N V
      {3'd0, 16'd0,     16'd0,     4'hF, 16'd0,     4'h4}, // R2 Z
      {3'd0, 16'd32768, 16'd1,     4'h0, 16'd32769, 4'h8}, // R2 N
      {3'd0, 16'd65535, 16'd1,     4'h0, 16'd0,     4'h5}, // R2 Z C
      {3'd1, 16'd1,     16'd1,     4'h0, 16'd0,     4'h4}, // R3 Z
      {3'd1, 16'd1,     16'd32767, 4'hF, 16'd32766, 4'h0}, // R3 plain
      {3'd1, 16'd32768, 16'd1,     4'h0, 16'd32769, 4'hB}, // R3 N V C
      {3'd1, 16'd65535, 16'd1,     4'h0, 16'd2,     4'h1}, // R3 borrow
      {3'd2, 16'd5,     16'd3,     4'hF, 16'd3,     4'h0}, // R4 greater
      {3'd2, 16'd3,     16'd5,     4'h0, 16'd5,     4'h9}, // R4 less
      {3'd2, 16'h8000,  16'd1,     4'h0, 16'd1,     4'h2}, // R4 overflow
      {3'd3, 16'd9,     16'h7FFF,  4'h1, 16'h8000,  4'hB}, // R5 inc V, C kept
      {3'd3, 16'd0,     16'hFFFF,  4'h0, 16'h0000,  4'h4}, // R5 inc wrap, C kept 0
      {3'd4, 16'd0,     16'h8000,  4'h0, 16'h7FFF,  4'h2}, // R5 dec V
      {3'd4, 16'd0,     16'h0000,  4'h1, 16'hFFFF,  4'h9}, // R5 dec wrap, C kept 1
      {3'd4, 16'd7,     16'h0001,  4'hF, 16'h0000,  4'h5}, // R5 dec to zero
      {3'd5, 16'h5555,  16'h1234,  4'h6, 16'h1234,  4'h6}, // R6
      {3'd7, 16'h0F0F,  16'hABCD,  4'h9, 16'hABCD,  4'h9}  // R6
   };

   function automatic string op_req(input logic [2:0] op);
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3, 3'd4: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_br(input string req, input logic [15:0] ins,
                           input logic [15:0] pc, input logic [3:0] flg,
                           input logic exp_t, input logic [15:0] exp_tgt);
      @(negedge clk);
      op_i = 3'd5; br_instr_i = ins; pc_i = pc; flags_i = flg;
      @(negedge clk);
      check(req, $sformatf("taken ins=%h flg=%h", ins, flg), {15'd0, taken_o}, {15'd0, exp_t});
      check(req, $sformatf("target ins=%h", ins), target_o, exp_tgt);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset with non-zero inputs
      src_i = 16'h1; dst_i = 16'hFFFF; op_i = 3'd0; flags_i = 4'hF;
      br_instr_i = 16'h01FF; pc_i = 16'h1234;
      repeat (3) @(negedge clk);
      check("R1", "reset result", result_o, 16'h0);
      check("R1", "reset flags", {12'd0, flags_o}, 16'h0);
      check("R1", "reset taken", {15'd0, taken_o}, 16'h0);
      check("R1", "reset target", target_o, 16'h0);
      rst_n = 1'b1;
      br_instr_i = 16'h0000;

      // R2..R6 vector walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {op_i, src_i, dst_i, flags_i} = VEC[i][58:20];
         @(negedge clk);
         check(op_req(VEC[i][58:56]), $sformatf("result vec %0d", i), result_o, VEC[i][19:4]);
         check(op_req(VEC[i][58:56]), $sformatf("flags vec %0d", i), {12'd0, flags_o}, {12'd0, VEC[i][3:0]});
      end

      // R12: outputs hold until the next rising edge
      @(negedge clk);
      op_i = 3'd0; src_i = 16'd2; dst_i = 16'd3; flags_i = 4'h0;
      #1;
      check("R12", "held before edge", result_o, 16'hABCD);
      @(negedge clk);
      check("R12", "updated after edge", result_o, 16'd5);

      // R7, R8: always-taken and targets
      check_br("R8", 16'h01FF, 16'h1000, 4'h0, 1'b1, 16'h0FFE);
      check_br("R7", 16'h0105, 16'h1000, 4'hF, 1'b1, 16'h100A);
      check_br("R7", 16'h0180, 16'h1000, 4'h0, 1'b1, 16'h0F00);
      check_br("R7", 16'h017F, 16'hFFF0, 4'h0, 1'b1, 16'h00EE);
      // R9 signed
      check_br("R9", 16'h0500, 16'h2000, 4'h8, 1'b1, 16'h2000);
      check_br("R9", 16'h0500, 16'h2000, 4'hA, 1'b0, 16'h2000);
      check_br("R9", 16'h0400, 16'h2000, 4'hA, 1'b1, 16'h2000);
      check_br("R9", 16'h0400, 16'h2000, 4'h8, 1'b0, 16'h2000);
      check_br("R9", 16'h0600, 16'h2000, 4'h0, 1'b1, 16'h2000);
      check_br("R9", 16'h0600, 16'h2000, 4'h4, 1'b0, 16'h2000);
      check_br("R9", 16'h0600, 16'h2000, 4'h8, 1'b0, 16'h2000);
      check_br("R9", 16'h0700, 16'h2000, 4'h4, 1'b1, 16'h2000);
      check_br("R9", 16'h0700, 16'h2000, 4'h2, 1'b1, 16'h2000);
      check_br("R9", 16'h0700, 16'h2000, 4'h0, 1'b0, 16'h2000);
      // R10 unsigned
      check_br("R10", 16'h8200, 16'h3000, 4'h0, 1'b1, 16'h3000);
      check_br("R10", 16'h8200, 16'h3000, 4'h1, 1'b0, 16'h3000);
      check_br("R10", 16'h8200, 16'h3000, 4'h4, 1'b0, 16'h3000);
      check_br("R10", 16'h8300, 16'h3000, 4'h4, 1'b1, 16'h3000);
      check_br("R10", 16'h8300, 16'h3000, 4'h0, 1'b0, 16'h3000);
      check_br("R10", 16'h8600, 16'h3000, 4'h0, 1'b1, 16'h3000);
      check_br("R10", 16'h8600, 16'h3000, 4'h1, 1'b0, 16'h3000);
      check_br("R10", 16'h8701, 16'h3000, 4'h1, 1'b1, 16'h3002);
      check_br("R10", 16'h8700, 16'h3000, 4'h0, 1'b0, 16'h3000);
      // R11 equality and unused codes
      check_br("R11", 16'h0300, 16'h4000, 4'h4, 1'b1, 16'h4000);
      check_br("R11", 16'h0300, 16'h4000, 4'h0, 1'b0, 16'h4000);
      check_br("R11", 16'h0200, 16'h4000, 4'h4, 1'b0, 16'h4000);
      check_br("R11", 16'h0200, 16'h4000, 4'h0, 1'b1, 16'h4000);
      check_br("R11", 16'h0000, 16'h4000, 4'h0, 1'b0, 16'h4000);
      check_br("R11", 16'h8000, 16'h4000, 4'hF, 1'b0, 16'h4000);
      check_br("R11", 16'hFF00, 16'h4000, 4'h0, 1'b0, 16'h4000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule